// File: doc/BRIEF.md
# Timer Control Register with Clock-Domain Enable Transfer

This block is the main 32-bit control word of a timer/counter peripheral. Software writes it through a simple full-word write port in the bus clock domain. It holds the timer configuration: four capture-enable bits, a one-shot DMA trigger mode, a host-synchronisation bit, a prescaler synchronisation select, a run-in-standby bit, a prescaler divider select and a dithering resolution. It also holds an enable bit and a software-reset bit.

The enable and software-reset bits are the only fields the counter clock domain needs to see at once. They travel there over a toggle request/acknowledge handshake. While the transfer is in flight, `busy_o` is high. Any write that arrives during that time is stalled with `wait_o`, so no transferred update is lost.

While the peripheral is enabled, the configuration fields are locked. A software reset takes priority over everything else in the same write. The reset-bit readback stays at 1 until the reset has reached the counter domain and its acknowledge has returned.

Top module: `tmr_ctrl_reg`

## Requirements
- R1: After `rst_ni` is deasserted, the read word is 0x00000000, `busy_o` and `wait_o` are 0, and both counter-domain outputs are 0.
- R2: While enable is 0, a write without bit 0 set stores these fields, and the read word returns them at the same positions:
  - capture enables at bits 27:24
  - DMA one-shot at bit 23
  - host sync at bit 15
  - prescaler sync at bits 13:12
  - run in standby at bit 11
  - prescaler select at bits 10:8
  - resolution at bits 6:5
  - enable at bit 1
- R3: While enable reads 1, writes leave every field other than enable and software reset unchanged. Enable itself stays writable.
- R4: A write with bit 0 set has these effects:
  - all configuration fields and enable are cleared, whatever the other bits of that write hold;
  - the read word becomes 0x00000001 on the next cycle;
  - bit 0 reads 0 again once `busy_o` has fallen.
- R5: Writing 0 to bit 0 starts no reset and has no effect of its own.
- R6: `busy_o` is high in the bus cycle after an accepted write that sets bit 0 or changes enable. It is 0 after any other accepted write. It falls within `BUSY_LIMIT` bus cycles.
- R7: While `busy_o` is high, a write request raises `wait_o` and is not taken. It is taken on the first cycle `busy_o` is low.
- R8: When `busy_o` falls, `cnt_en_o` equals the enable bit that was written. Each software reset gives exactly one single-cycle `cnt_swrst_o` pulse in the counter domain, with `cnt_en_o` low.
- R9: Bits 31:28, 22:16, 14, 7 and 4:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| cnt_clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_en_i | input | 1 | Write request, held until `wait_o` is low |
| wr_data_i | input | 32 | Write data word |
| wait_o | output | 1 | Write stalled because a transfer is pending |
| rd_data_o | output | 32 | Current register contents |
| busy_o | output | 1 | Enable/reset transfer to counter domain in progress |
| cnt_en_o | output | 1 | Enable as seen in the counter domain |
| cnt_swrst_o | output | 1 | One-cycle software reset pulse in the counter domain |

## Verification
On every cycle, assertions check four things:
- the configuration lock while enabled;
- the cleared state that follows a reset write;
- that nothing is taken while busy;
- the busy time limit and the single-cycle shape of the counter-domain reset pulse.

The full field map is shown only by the bench. It uses walking-one sweeps and a reference model over many written words, which also cover the reserved zeros and the enable value that arrives in the counter domain. The same goes for stalling a second write behind a pending transfer and for counting reset pulses across the two clocks.

// File: rtl/tmr_ctrl_pkg.sv
package tmr_ctrl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned N_CAPT = 4;

  localparam int unsigned BIT_SWRST = 0;
  localparam int unsigned BIT_EN    = 1;
  localparam int unsigned LSB_RES   = 5;
  localparam int unsigned LSB_PRESC = 8;
  localparam int unsigned BIT_STBY  = 11;
  localparam int unsigned LSB_PSYNC = 12;
  localparam int unsigned BIT_HOST  = 15;
  localparam int unsigned BIT_DMA1  = 23;
  localparam int unsigned LSB_CAPT  = 24;

  typedef struct packed {
    logic [N_CAPT-1:0] capt_en;
    logic              dma_once;
    logic              host_sync;
    logic [1:0]        presc_sync;
    logic              run_stby;
    logic [2:0]        presc_sel;
    logic [1:0]        dith_res;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

  function automatic cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.capt_en    = w[LSB_CAPT +: N_CAPT];
    c.dma_once   = w[BIT_DMA1];
    c.host_sync  = w[BIT_HOST];
    c.presc_sync = w[LSB_PSYNC +: 2];
    c.run_stby   = w[BIT_STBY];
    c.presc_sel  = w[LSB_PRESC +: 3];
    c.dith_res   = w[LSB_RES +: 2];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c, input logic en,
                                                    input logic rst);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LSB_CAPT +: N_CAPT] = c.capt_en;
    w[BIT_DMA1]           = c.dma_once;
    w[BIT_HOST]           = c.host_sync;
    w[LSB_PSYNC +: 2]     = c.presc_sync;
    w[BIT_STBY]           = c.run_stby;
    w[LSB_PRESC +: 3]     = c.presc_sel;
    w[LSB_RES +: 2]       = c.dith_res;
    w[BIT_EN]             = en;
    w[BIT_SWRST]          = rst;
    return w;
  endfunction
endpackage

// File: rtl/tmr_ctrl_sync2.sv
module tmr_ctrl_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic              wait_o,
  output logic              launch_o,
  output logic              en_o,
  output logic              swrst_o,
  output logic [WORD_W-1:0] rd_data_o
);
  cfg_t cfg_q;
  logic en_q, swrst_q;
  logic wr_fire, rst_req;

  assign wr_fire  = wr_en_i & ~busy_i;
  assign wait_o   = wr_en_i & busy_i;
  assign rst_req  = wr_fire & wr_data_i[BIT_SWRST];
  // a transfer is needed only when the domain crossing bits change meaning
  assign launch_o = wr_fire & (wr_data_i[BIT_SWRST] | (wr_data_i[BIT_EN] != en_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      en_q    <= 1'b0;
      swrst_q <= 1'b0;
    end else if (rst_req) begin
      cfg_q   <= '0;
      en_q    <= 1'b0;
      swrst_q <= 1'b1;
    end else begin
      if (swrst_q && !busy_i) swrst_q <= 1'b0;
      if (wr_fire) begin
        en_q <= wr_data_i[BIT_EN];
        if (!en_q) cfg_q <= word_to_cfg(wr_data_i);
      end
    end
  end

  assign en_o      = en_q;
  assign swrst_o   = swrst_q;
  assign rd_data_o = cfg_to_word(cfg_q, en_q, swrst_q);

  p_cfg_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !rst_req) |=> $stable(cfg_q));

  p_swrst_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> (cfg_q == '0 && !en_q && swrst_q));

  p_swrst_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> busy_i);

  p_hold_while_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_en_i) |=> ($stable(en_q) && $stable(cfg_q)));
endmodule

// File: rtl/tmr_ctrl_cdc.sv
module tmr_ctrl_cdc #(
  parameter int unsigned BUSY_LIMIT = 64
) (
  input  logic clk_i,
  input  logic cnt_clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic en_i,
  input  logic swrst_i,
  output logic busy_o,
  output logic cnt_en_o,
  output logic cnt_swrst_o
);
  localparam int unsigned BCNT_W = $clog2(BUSY_LIMIT + 1) + 1;

  logic req_q, req_sync;
  logic ack_q, ack_sync;
  logic cnt_en_q, cnt_swrst_q;

  // bus side: request toggle, payload (en_i/swrst_i) is held stable while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       req_q <= 1'b0;
    else if (launch_i) req_q <= ~req_q;
  end

  tmr_ctrl_sync2 #(.W(1)) u_req_sync (
    .clk_i (cnt_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_q),
    .q_o   (req_sync)
  );

  // counter side: capture payload and acknowledge on a new request
  always_ff @(posedge cnt_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q       <= 1'b0;
      cnt_en_q    <= 1'b0;
      cnt_swrst_q <= 1'b0;
    end else if (req_sync != ack_q) begin
      ack_q       <= req_sync;
      cnt_en_q    <= en_i & ~swrst_i;
      cnt_swrst_q <= swrst_i;
    end else begin
      cnt_swrst_q <= 1'b0;
    end
  end

  tmr_ctrl_sync2 #(.W(1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_q),
    .q_o   (ack_sync)
  );

  assign busy_o      = req_q ^ ack_sync;
  assign cnt_en_o    = cnt_en_q;
  assign cnt_swrst_o = cnt_swrst_q;

  logic [BCNT_W-1:0] busy_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt_q <= '0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
    else             busy_cnt_q <= '0;
  end

  p_busy_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt_q <= BCNT_W'(BUSY_LIMIT));

  p_launch_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_o);

  p_swrst_pulse_r8: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    cnt_swrst_q |=> !cnt_swrst_q);

  p_swrst_disabled_r8: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    cnt_swrst_q |-> !cnt_en_q);
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_ctrl_pkg::*;
#(
  parameter int unsigned BUSY_LIMIT = 64
) (
  input  logic        clk_i,
  input  logic        cnt_clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic        wait_o,
  output logic [31:0] rd_data_o,
  output logic        busy_o,
  output logic        cnt_en_o,
  output logic        cnt_swrst_o
);
  logic launch, en, swrst, busy;

  tmr_ctrl_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .busy_i   (busy),
    .wait_o   (wait_o),
    .launch_o (launch),
    .en_o     (en),
    .swrst_o  (swrst),
    .rd_data_o(rd_data_o)
  );

  tmr_ctrl_cdc #(.BUSY_LIMIT(BUSY_LIMIT)) u_cdc (
    .clk_i      (clk_i),
    .cnt_clk_i  (cnt_clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .en_i       (en),
    .swrst_i    (swrst),
    .busy_o     (busy),
    .cnt_en_o   (cnt_en_o),
    .cnt_swrst_o(cnt_swrst_o)
  );

  assign busy_o = busy;

  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[31:28] == '0) && (rd_data_o[22:16] == '0) && !rd_data_o[14] &&
    !rd_data_o[7] && (rd_data_o[4:2] == '0));
endmodule

// File: tb/tb_tmr_ctrl_reg.sv
`timescale 1ns/1ps
module tb_tmr_ctrl_reg;
  logic        clk = 1'b0, cnt_clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wait_w, busy, cnt_en, cnt_swrst;
  logic [31:0] rd_data;

  int checks = 0, fails = 0, pulses = 0, cycles = 0;
  logic        m_en = 1'b0;
  logic [31:0] m_cfg = '0;
  logic [31:0] cfg_mask;

  always #5 clk = ~clk;
  always #6.5 cnt_clk = ~cnt_clk;

  tmr_ctrl_reg dut (
    .clk_i(clk), .cnt_clk_i(cnt_clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wait_o(wait_w),
    .rd_data_o(rd_data), .busy_o(busy), .cnt_en_o(cnt_en), .cnt_swrst_o(cnt_swrst)
  );

  always @(negedge cnt_clk) if (cnt_swrst) pulses++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
    checks++;
    if (n > 64) begin
      fails++;
      $display("FAIL %s busy cycles act=%0d exp<=64", req, n);
    end
  endtask

  // drive at negedge, hold until accepted, check busy one cycle later (R6)
  task automatic wr(input logic [31:0] d);
    logic exp_busy;
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    while (wait_w) @(negedge clk);
    exp_busy = d[0] | (d[1] != m_en);
    @(negedge clk);
    wr_en = 1'b0;
    if (d[0]) begin m_cfg = '0; m_en = 1'b0; end
    else begin
      if (!m_en) m_cfg = d & cfg_mask;
      m_en = d[1];
    end
    chk("R6 busy after write", {31'd0, busy}, {31'd0, exp_busy});
  endtask

  task automatic wr_settle(input logic [31:0] d, input string req);
    wr(d);
    wait_idle(req);
    @(negedge clk);
    chk(req, rd_data, m_cfg | {30'd0, m_en, 1'b0});
    chk("R8 counter enable", {31'd0, cnt_en}, {31'd0, m_en});
  endtask

  initial begin
    logic [31:0] lfsr;
    int p0;
    cfg_mask = '0;
    cfg_mask[27:24] = '1; cfg_mask[23] = 1'b1; cfg_mask[15] = 1'b1;
    cfg_mask[13:12] = '1; cfg_mask[11] = 1'b1; cfg_mask[10:8] = '1; cfg_mask[6:5] = '1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", rd_data, 32'h0);
    chk("R1 reset flags", {28'd0, busy, wait_w, cnt_en, cnt_swrst}, 32'h0);

    // R2/R9 walking one over all bits above bit 1, enable stays 0 (R5: bit0=0)
    for (int b = 2; b < 32; b++) wr_settle(32'h1 << b, "R2 R9 walking one");
    wr_settle(32'hFFFF_FFFC, "R2 R9 all fields");
    wr_settle(32'h0000_0000, "R5 zero write");

    // R3 lock sweep with enable toggling
    lfsr = 32'hACE1_2BAD;
    for (int i = 0; i < 12; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr_settle((lfsr & ~32'h1) | 32'h2, "R3 enable with config");
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr_settle((lfsr & ~32'h1) | 32'h2, "R3 locked write");
      wr_settle(lfsr & ~32'h3, "R3 disable keeps config");
      wr_settle(~lfsr & ~32'h3, "R2 unlocked write");
    end

    // R7 second write stalls behind pending enable transfer
    wr(32'h0F00_0002);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_0000;
    @(negedge clk);
    chk("R7 wait raised", {31'd0, wait_w}, {31'd0, busy});
    chk("R7 not taken", rd_data, 32'h0F00_0002);
    while (wait_w) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    m_en = 1'b0;
    chk("R7 taken after busy", rd_data, 32'h0F00_0000);
    wait_idle("R7 idle");

    // R4/R8 software reset overrides other bits, enabled and disabled
    for (int k = 0; k < 3; k++) begin
      wr_settle(32'h0A80_9A42, "R4 setup");
      p0 = pulses;
      wr(32'hFFFF_FFFF);
      chk("R4 reset in progress", rd_data, 32'h1);
      wait_idle("R4 reset idle");
      @(negedge clk);
      chk("R4 reset done", rd_data, 32'h0);
      repeat (4) @(negedge cnt_clk);
      chk("R8 one pulse", pulses - p0, 1);
      chk("R8 counter disabled", {31'd0, cnt_en}, 32'h0);
    end
    p0 = pulses;
    wr(32'h0000_0001);
    wait_idle("R4 reset while disabled");
    @(negedge clk);
    chk("R4 reset while disabled", rd_data, 32'h0);
    repeat (4) @(negedge cnt_clk);
    chk("R8 pulse disabled", pulses - p0, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule